// File: doc/BRIEF.md
# Radio Interrupt and Status Controller

This block gathers the event sources of a low-power radio into a single active-low interrupt line. It also builds a status word that a host reads over a serial frame. Eight sources share the line: transmit register empty, receive FIFO at its fill level, power-on reset, transmit underrun, FIFO overflow, wake-up timer, external pin and low battery. Each source follows its own clear rule:

- Some are cleared by the status read.
- One follows a pin level and has no latch.
- Two are cleared only by their data action or by switching their function off.
- For low battery, the read releases the interrupt line but the status bit keeps showing the supply condition.

The serial side works in the system clock domain. A frame is open while `csN` is low, and one bit moves on each cycle with `sckStb` high.

- If the first bit of a frame is 0, the frame is a status read. The block captures the status word on that strobe and applies the read-clear rules on that same strobe.
- Each later strobe moves the next word bit to `sdo`, most significant bit first.
- A frame whose first bit is 1 is some other command and is ignored here.

A sleep request is passed through only while no interrupt is pending.

Top module: `radio_irq_top`

## Requirements
- R1: A frame whose first strobed bit is 0 is a status read. A frame whose first bit is 1 leaves `sdo` at 0 and clears no flag.
- R2: The status word is `STATUS_W = 15 + OFFS_LOW_W` bits wide and is sent MSB first. With the default of 19 bits, the layout is:
  - bit 18: transmit-empty flag; bit 17: FIFO-level flag; bit 16: power-on flag; bit 15: underrun flag; bit 14: overflow flag; bit 13: wake flag.
  - bit 12: external flag; bit 11: low-battery status.
  - bits 10..5: `fifoEmpty`, `antTuneHit`, `rssiHit`, `dataQualOk`, `clkLocked`, `afcToggle`, in that order.
  - bit 4: offset sign; bits 3..0: offset low bits.
  - After the command strobe `sdo` shows bit 18, and after the n-th further strobe it shows bit 18-n.
- R3: `irqN` is low exactly while some latched flag, the external level or the low-battery latch is active. Reset sets the power-on flag, so `irqN` is low after reset.
- R4: The power-on flag and the wake flag are cleared by a status read. The wake flag is set by a `wakeTick` pulse while `wakeEn` is high.
- R5: The external flag equals `extEn & ~extPinN` at every moment, with no latch. A status read does not clear it.
- R6: A rise of `battLow` while `battEn` is high latches a low-battery interrupt. A status read releases `irqN` for it, but status bit 11 stays 1 while `battLow` remains high.
- R7: The transmit-empty flag and the FIFO-level flag follow their level inputs and survive a status read.
  - `txWrite` clears the transmit-empty flag; `fifoRead` clears the FIFO-level flag.
  - If the level input is still high at the clear, the flag is 0 for one cycle and then set again.
- R8: A `txUnderrun` pulse sets both the transmit-empty flag and the underrun flag. The underrun flag survives both `txWrite` and a status read.
  - A `fifoOverflow` pulse sets both the FIFO-level flag and the overflow flag. A status read clears only the overflow flag.
- R9: Dropping an enable clears the flags it owns on the next edge and blocks new settings:
  - `txPathEn`: transmit-empty and underrun flags.
  - `rxPathEn`: FIFO-level and overflow flags.
  - `wakeEn`: wake flag.
  - `battEn`: low-battery latch and status bit.
- R10: `sleepGrant` is `sleepReq` when `irqN` is high and 0 otherwise.
- R11: The word sent in a read frame is the value at the command strobe. An event arriving during the shift does not appear in that word but stays latched afterwards.
- R12: The offset field carries the two's-complement sign in bit 4 and the low offset bits in bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txPathEn | input | 1 | Transmitter and its data register enabled |
| rxPathEn | input | 1 | Receiver and its FIFO enabled |
| wakeEn | input | 1 | Wake-up timer enabled |
| battEn | input | 1 | Low-battery detector enabled |
| extEn | input | 1 | External pin used as interrupt source |
| txRegEmpty | input | 1 | Level: transmit register wants a byte |
| txWrite | input | 1 | Pulse: transmit register written |
| txUnderrun | input | 1 | Pulse: transmit register ran dry |
| fifoLevelHit | input | 1 | Level: FIFO fill reached threshold |
| fifoRead | input | 1 | Pulse: FIFO read by threshold amount |
| fifoOverflow | input | 1 | Pulse: FIFO overflowed |
| wakeTick | input | 1 | Pulse: wake-up timer expired |
| extPinN | input | 1 | External interrupt pin, active low |
| battLow | input | 1 | Level: supply below threshold |
| fifoEmpty | input | 1 | Live status: FIFO empty |
| antTuneHit | input | 1 | Live status: strong RF at antenna |
| rssiHit | input | 1 | Live status: signal above limit |
| dataQualOk | input | 1 | Live status: data quality good |
| clkLocked | input | 1 | Live status: clock recovery locked |
| afcToggle | input | 1 | Live status: toggles each AFC cycle |
| offsSign | input | 1 | Sign bit of frequency offset |
| offsLow | input | OFFS_LOW_W | Low bits of frequency offset |
| csN | input | 1 | Serial frame select, active low |
| sckStb | input | 1 | Serial bit strobe, one clock wide |
| sdi | input | 1 | Serial data in |
| sleepReq | input | 1 | Request to enter sleep |
| sdo | output | 1 | Serial status data out |
| irqN | output | 1 | Interrupt, active low |
| sleepGrant | output | 1 | Sleep request passed on |

## Verification
The bench builds the block with its default `OFFS_LOW_W` of 4. This gives the 19-bit word, so every word position, including the offset sign and low bits, is compared bit by bit in frames of 19 strobes. At that width a full read takes under 60 cycles. This leaves room to exercise every clear rule in turn:

- the level re-assert cycle after a FIFO read;
- an event injected mid-shift;
- the underrun flag surviving a register write;
- the low-battery bit outliving its released interrupt.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
  typedef struct packed {
    logic readHit;
    logic shiftStb;
    logic frameRead;
  } ctrlStrb_t;
endpackage

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl
  import radio_irq_pkg::*;
#(
  parameter int STATUS_W = 19
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sckStb,
  input  logic      sdi,
  output ctrlStrb_t strb
);
  localparam int CNT_MAX = STATUS_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] bitCnt;
  logic             reading;
  logic             stbLive;
  logic             firstBit;

  assign stbLive  = sckStb & ~csN;
  assign firstBit = (bitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      reading <= 1'b0;
    end else if (csN) begin
      bitCnt  <= '0;
      reading <= 1'b0;
    end else if (sckStb) begin
      if (bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
      if (firstBit && !sdi) reading <= 1'b1;
    end
  end

  always_comb begin
    strb.readHit   = stbLive & firstBit & ~sdi;
    strb.shiftStb  = stbLive & reading;
    strb.frameRead = reading;
  end

  AST_FRAME_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameRead && csN |=> !strb.frameRead); // R1
  AST_READ_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    strb.readHit |=> strb.frameRead); // R1
endmodule

// File: rtl/radio_irq_datapath.sv
module radio_irq_datapath
  import radio_irq_pkg::*;
#(
  parameter int OFFS_LOW_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrb_t             strb,
  input  logic                  txPathEn,
  input  logic                  rxPathEn,
  input  logic                  wakeEn,
  input  logic                  battEn,
  input  logic                  extEn,
  input  logic                  txRegEmpty,
  input  logic                  txWrite,
  input  logic                  txUnderrun,
  input  logic                  fifoLevelHit,
  input  logic                  fifoRead,
  input  logic                  fifoOverflow,
  input  logic                  wakeTick,
  input  logic                  extPinN,
  input  logic                  battLow,
  input  logic [5:0]            liveBits,
  input  logic                  offsSign,
  input  logic [OFFS_LOW_W-1:0] offsLow,
  output logic                  sdo,
  output logic                  irqN
);
  localparam int STATUS_W = 15 + OFFS_LOW_W;
  localparam int N_LVL    = 2;

  // level-with-data-clear pair: index 0 transmit empty, 1 FIFO level
  logic [N_LVL-1:0] lvlFlag, lvlEn, lvlSrc, lvlClr, lvlForce;
  logic porFlag, rgurFlag, ffovFlag, wkupFlag, lbdIrq, battPrev;
  logic extLvl, battLvl, battRise;
  logic [STATUS_W-1:0] shReg, snapWord;

  assign lvlEn    = {rxPathEn, txPathEn};
  assign lvlSrc   = {fifoLevelHit, txRegEmpty};
  assign lvlClr   = {fifoRead, txWrite};
  assign lvlForce = {fifoOverflow, txUnderrun};

  generate
    for (genvar i = 0; i < N_LVL; i++) begin : gLvl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) lvlFlag[i] <= 1'b0;
        else       lvlFlag[i] <= lvlEn[i] &
                                 ((~lvlClr[i] & (lvlFlag[i] | lvlSrc[i])) | lvlForce[i]);
      end
    end
  endgenerate

  assign extLvl   = extEn & ~extPinN;
  assign battLvl  = battEn & battLow;
  assign battRise = battLvl & ~battPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porFlag  <= 1'b1;
      rgurFlag <= 1'b0;
      ffovFlag <= 1'b0;
      wkupFlag <= 1'b0;
      lbdIrq   <= 1'b0;
      battPrev <= 1'b0;
    end else begin
      porFlag  <= porFlag & ~strb.readHit;
      rgurFlag <= txPathEn & (rgurFlag | txUnderrun);
      ffovFlag <= rxPathEn & ((ffovFlag & ~strb.readHit) | fifoOverflow);
      wkupFlag <= wakeEn & ((wkupFlag & ~strb.readHit) | wakeTick);
      lbdIrq   <= battEn & ((lbdIrq & ~strb.readHit) | battRise);
      battPrev <= battLvl;
    end
  end

  assign snapWord = {lvlFlag[0], lvlFlag[1], porFlag, rgurFlag, ffovFlag, wkupFlag,
                     extLvl, battLvl, liveBits, offsSign, offsLow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shReg <= '0;
    else if (strb.readHit)  shReg <= snapWord;
    else if (strb.shiftStb) shReg <= {shReg[STATUS_W-2:0], 1'b0};
  end

  assign sdo  = strb.frameRead & shReg[STATUS_W-1];
  assign irqN = ~(|lvlFlag | porFlag | rgurFlag | ffovFlag | wkupFlag | extLvl | lbdIrq);

  AST_POR_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.readHit |=> !porFlag); // R4
  AST_WAKE_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.readHit && !wakeTick |=> !wkupFlag); // R4
  AST_LBD_PIN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    strb.readHit && battPrev |=> !lbdIrq); // R6
  AST_FIFO_DATA_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead && !fifoOverflow |=> !lvlFlag[1]); // R7
  AST_UNDERRUN_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    txPathEn && txUnderrun |=> lvlFlag[0] && rgurFlag); // R8
  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txPathEn && rgurFlag |=> rgurFlag); // R8
  AST_RX_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !rxPathEn |=> !lvlFlag[1] && !ffovFlag); // R9
endmodule

// File: rtl/radio_irq_top.sv
module radio_irq_top
  import radio_irq_pkg::*;
#(
  parameter int OFFS_LOW_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  txPathEn,
  input  logic                  rxPathEn,
  input  logic                  wakeEn,
  input  logic                  battEn,
  input  logic                  extEn,
  input  logic                  txRegEmpty,
  input  logic                  txWrite,
  input  logic                  txUnderrun,
  input  logic                  fifoLevelHit,
  input  logic                  fifoRead,
  input  logic                  fifoOverflow,
  input  logic                  wakeTick,
  input  logic                  extPinN,
  input  logic                  battLow,
  input  logic                  fifoEmpty,
  input  logic                  antTuneHit,
  input  logic                  rssiHit,
  input  logic                  dataQualOk,
  input  logic                  clkLocked,
  input  logic                  afcToggle,
  input  logic                  offsSign,
  input  logic [OFFS_LOW_W-1:0] offsLow,
  input  logic                  csN,
  input  logic                  sckStb,
  input  logic                  sdi,
  input  logic                  sleepReq,
  output logic                  sdo,
  output logic                  irqN,
  output logic                  sleepGrant
);
  localparam int STATUS_W = 15 + OFFS_LOW_W;

  ctrlStrb_t strb;

  radio_irq_ctrl #(.STATUS_W(STATUS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sckStb(sckStb), .sdi(sdi), .strb(strb)
  );

  radio_irq_datapath #(.OFFS_LOW_W(OFFS_LOW_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txPathEn(txPathEn), .rxPathEn(rxPathEn), .wakeEn(wakeEn), .battEn(battEn),
    .extEn(extEn), .txRegEmpty(txRegEmpty), .txWrite(txWrite), .txUnderrun(txUnderrun),
    .fifoLevelHit(fifoLevelHit), .fifoRead(fifoRead), .fifoOverflow(fifoOverflow),
    .wakeTick(wakeTick), .extPinN(extPinN), .battLow(battLow),
    .liveBits({fifoEmpty, antTuneHit, rssiHit, dataQualOk, clkLocked, afcToggle}),
    .offsSign(offsSign), .offsLow(offsLow), .sdo(sdo), .irqN(irqN)
  );

  assign sleepGrant = sleepReq & irqN;

  AST_SLEEP_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !irqN && $past(!irqN) |-> !sleepGrant); // R10
endmodule

// File: tb/radio_irq_top_test.sv
module radio_irq_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txPathEn = 0, rxPathEn = 0, wakeEn = 0, battEn = 0, extEn = 0;
  logic txRegEmpty = 0, txWrite = 0, txUnderrun = 0;
  logic fifoLevelHit = 0, fifoRead = 0, fifoOverflow = 0;
  logic wakeTick = 0, extPinN = 1, battLow = 0;
  logic fifoEmpty = 0, antTuneHit = 0, rssiHit = 0, dataQualOk = 0, clkLocked = 0, afcToggle = 0;
  logic offsSign = 0;
  logic [3:0] offsLow = '0;
  logic csN = 1, sckStb = 0, sdi = 0, sleepReq = 0;
  logic sdo, irqN, sleepGrant;

  int nRun = 0, nFail = 0;
  bit done = 0;
  bit monGo = 0;
  logic expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  radio_irq_top uut (
    .clk(clk), .rstN(rstN), .txPathEn(txPathEn), .rxPathEn(rxPathEn), .wakeEn(wakeEn),
    .battEn(battEn), .extEn(extEn), .txRegEmpty(txRegEmpty), .txWrite(txWrite),
    .txUnderrun(txUnderrun), .fifoLevelHit(fifoLevelHit), .fifoRead(fifoRead),
    .fifoOverflow(fifoOverflow), .wakeTick(wakeTick), .extPinN(extPinN), .battLow(battLow),
    .fifoEmpty(fifoEmpty), .antTuneHit(antTuneHit), .rssiHit(rssiHit),
    .dataQualOk(dataQualOk), .clkLocked(clkLocked), .afcToggle(afcToggle),
    .offsSign(offsSign), .offsLow(offsLow), .csN(csN), .sckStb(sckStb), .sdi(sdi),
    .sleepReq(sleepReq), .sdo(sdo), .irqN(irqN), .sleepGrant(sleepGrant)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] mkWord(input logic rgit, ffit, por, rgur, ffov, wkup, ext, lbd,
                                         input logic [5:0] live, input logic sgn,
                                         input logic [3:0] low);
    return {rgit, ffit, por, rgur, ffov, wkup, ext, lbd, live, sgn, low};
  endfunction

  // monitor: pops one expected bit per shifted position
  always @(posedge clk) begin
    if (monGo) begin
      #4;
      nRun++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R2 unexpected sample actual=%0b expected=none", sdo);
      end else begin
        logic e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (sdo !== e) begin
          nFail++;
          $display("FAIL %s status bit actual=%0b expected=%0b", t, sdo, e);
        end
      end
    end
  end

  // driver: pushes the expected word, then runs a read frame
  task automatic doRead(input logic [18:0] exp, input string tag, input int midTick);
    for (int b = 18; b >= 0; b--) begin
      expQ.push_back(exp[b]);
      tagQ.push_back(tag);
    end
    for (int i = 0; i < 19; i++) begin
      @(negedge clk); csN = 0; sckStb = 1; sdi = 0;
      @(negedge clk); sckStb = 0; monGo = 1;
      if (i == midTick) wakeTick = 1;
      @(negedge clk); monGo = 0; wakeTick = 0;
    end
    @(negedge clk); csN = 1;
    @(negedge clk);
  endtask

  task automatic otherCmd();
    @(negedge clk); csN = 0; sckStb = 1; sdi = 1;
    @(negedge clk); sckStb = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sckStb = 1; sdi = 0;
      @(negedge clk); sckStb = 0;
      chk("R1 other command sdo", sdo, 0);
    end
    @(negedge clk); csN = 1;
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    sleepReq = 1;
    @(negedge clk);
    chk("R3 reset irqN", irqN, 0);
    chk("R10 sleep blocked", sleepGrant, 0);

    otherCmd();
    chk("R1 por kept", irqN, 0);

    offsSign = 1; offsLow = 4'b0110;
    doRead(mkWord(0,0,1,0,0,0,0,0,6'b0,1,4'b0110), "R12", -1);
    chk("R4 por cleared", irqN, 1);
    chk("R10 sleep granted", sleepGrant, 1);
    offsSign = 0; offsLow = 0;

    extEn = 1; extPinN = 0;
    @(negedge clk); chk("R5 ext low", irqN, 0);
    extPinN = 1;
    @(negedge clk); chk("R5 ext follows", irqN, 1);
    extPinN = 0;
    doRead(mkWord(0,0,0,0,0,0,1,0,6'b0,0,4'b0), "R5", -1);
    chk("R5 ext not latched read", irqN, 0);
    extPinN = 1; extEn = 0;
    @(negedge clk); chk("R5 ext released", irqN, 1);

    wakeEn = 1;
    pulse(wakeTick);
    chk("R4 wake set", irqN, 0);
    doRead(mkWord(0,0,0,0,0,1,0,0,6'b0,0,4'b0), "R4", -1);
    chk("R4 wake cleared", irqN, 1);

    fifoEmpty = 1; dataQualOk = 1; afcToggle = 1; offsLow = 4'b0011;
    doRead(mkWord(0,0,0,0,0,0,0,0,6'b100101,0,4'b0011), "R11", 5);
    chk("R11 mid event latched", irqN, 0);
    doRead(mkWord(0,0,0,0,0,1,0,0,6'b100101,0,4'b0011), "R11", -1);
    chk("R11 cleared", irqN, 1);
    wakeEn = 0; fifoEmpty = 0; dataQualOk = 0; afcToggle = 0; offsLow = 0;

    battEn = 1; battLow = 1;
    @(negedge clk); @(negedge clk);
    chk("R6 lbd irq", irqN, 0);
    doRead(mkWord(0,0,0,0,0,0,0,1,6'b0,0,4'b0), "R6", -1);
    chk("R6 pin released", irqN, 1);
    doRead(mkWord(0,0,0,0,0,0,0,1,6'b0,0,4'b0), "R6", -1);
    battLow = 0; battEn = 0;

    txPathEn = 1; txRegEmpty = 1;
    @(negedge clk); txRegEmpty = 0;
    @(negedge clk); chk("R7 tx empty set", irqN, 0);
    doRead(mkWord(1,0,0,0,0,0,0,0,6'b0,0,4'b0), "R7", -1);
    chk("R7 survives read", irqN, 0);
    pulse(txWrite);
    chk("R7 write clears", irqN, 1);

    rxPathEn = 1; fifoLevelHit = 1;
    @(negedge clk); @(negedge clk);
    chk("R7 fifo level set", irqN, 0);
    fifoRead = 1;
    @(negedge clk); fifoRead = 0;
    chk("R7 fifo read clears", irqN, 1);
    @(negedge clk); chk("R7 level re-asserts", irqN, 0);
    fifoLevelHit = 0; fifoRead = 1;
    @(negedge clk); fifoRead = 0;
    chk("R7 fifo cleared", irqN, 1);

    pulse(txUnderrun);
    chk("R8 underrun irq", irqN, 0);
    doRead(mkWord(1,0,0,1,0,0,0,0,6'b0,0,4'b0), "R8", -1);
    pulse(txWrite);
    chk("R8 underrun holds", irqN, 0);
    doRead(mkWord(0,0,0,1,0,0,0,0,6'b0,0,4'b0), "R8", -1);
    txPathEn = 0;
    @(negedge clk); chk("R9 tx off clears", irqN, 1);
    txRegEmpty = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 tx off blocks", irqN, 1);
    txRegEmpty = 0;

    pulse(fifoOverflow);
    chk("R8 overflow irq", irqN, 0);
    doRead(mkWord(0,1,0,0,1,0,0,0,6'b0,0,4'b0), "R8", -1);
    doRead(mkWord(0,1,0,0,0,0,0,0,6'b0,0,4'b0), "R8", -1);
    rxPathEn = 0;
    @(negedge clk); chk("R9 rx off clears", irqN, 1);
    pulse(fifoOverflow);
    chk("R9 rx off blocks", irqN, 1);
    pulse(wakeTick);
    chk("R9 wake off blocks", irqN, 1);
    doRead(mkWord(0,0,0,0,0,0,0,0,6'b0,0,4'b0), "R9", -1);

    chk("R2 queue drained", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule